// File: doc/BRIEF.md
# Convert-Start Serial Readout Interface

This block is the host-facing end of a sampled-data converter. A host pulls an active-low convert-start line low to request one conversion. The block latches the channel select, sends a one-cycle start request with that channel to the converter, and drives its single data line low to show busy. When the converter strobes done with a result, the data line goes high to show ready. The host then supplies serial clock pulses, and each falling edge moves the next result bit onto the line, most significant bit first.

A host that samples on rising edges of its clock collects a leading 1 followed by the result. It closes the cycle by raising convert-start, which releases the line. If convert-start rises before the frame is complete, the conversion is abandoned. The line is then held low for a short, fixed number of clock cycles and released. Convert-start and the serial clock are asynchronous to the block clock and are synchronised on entry.

Top module: `cvs_readout`

## Requirements
- R1: While reset is high, and after reset is released until the first accepted convert-start fall, the data line is driven high (`sd_oe`=1, `sd_o`=1).
- R2: A falling edge of `cs_n` seen while idle or in the post-reset state starts a conversion. The block gives a single-cycle `conv_go` pulse, `conv_ch` takes the value of `chan_sel`, and the line is driven low (busy).
- R3: A `conv_done` strobe while busy captures `conv_result` and drives the line high (ready).
- R4: Each `sclk` falling edge during the transfer moves the next bit onto the line, MSB first. A host sampling on the 16 rising edges collects the value {1'b1, result}.
- R5: After the 16th `sclk` falling edge, the line is driven low until `cs_n` rises. `cs_n` rising then releases the line (`sd_oe`=0).
- R6: If `cs_n` rises before 16 `sclk` falling edges, whether still busy or mid-transfer, the conversion is abandoned. The line is driven low for ABORT_CYC clock cycles and then released.
- R7: `conv_ch` keeps the channel latched at the start for the whole conversion, even if `chan_sel` changes.
- R8: A `cs_n` falling edge during the abandon window is ignored. No `conv_go` is issued, and the line is released at the end of the window.
- R9: `conv_done` outside the busy state is ignored, and `sclk` edges while busy are ignored (the line stays low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Convert-start, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| chan_sel | input | 1 | Channel select, sampled at the start |
| conv_result | input | RES_W | Result word from the converter |
| conv_done | input | 1 | Converter result-valid strobe |
| conv_go | output | 1 | One-cycle start request to the converter |
| conv_ch | output | 1 | Channel latched for the current conversion |
| sd_o | output | 1 | Data line value |
| sd_oe | output | 1 | Data line output enable (0 = high impedance) |

## Verification
The hardest state to reach is the abandon window while a new convert-start fall arrives. Both edges pass through the synchroniser, so the second fall must be placed inside a window only ABORT_CYC cycles long. The bench raises `cs_n` mid-transfer, lowers it again four cycles later, and then checks that no start request appeared and that the line is released on time. Early release straight from busy, and stray done and clock edges, are driven in the same directed way.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

    typedef enum logic [2:0] {
        ST_RSTHI = 3'd0,
        ST_IDLE  = 3'd1,
        ST_BUSY  = 3'd2,
        ST_XFER  = 3'd3,
        ST_HOLD  = 3'd4,
        ST_ABORT = 3'd5
    } rd_state_e;

    typedef struct packed {
        logic oe;
        logic val;
    } line_t;

    // Data line drive for each state; msb is the head of the shift register.
    function automatic line_t line_drive(rd_state_e st, logic msb);
        line_t d;
        case (st)
            ST_RSTHI:          d = '{oe: 1'b1, val: 1'b1};
            ST_BUSY, ST_ABORT: d = '{oe: 1'b1, val: 1'b0};
            ST_XFER, ST_HOLD:  d = '{oe: 1'b1, val: msb};
            default:           d = '{oe: 1'b0, val: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/cvs_sync.sv
module cvs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/cvs_shifter.sv
module cvs_shifter #(
    parameter int RES_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [RES_W-1:0] data,
    input  logic             shift,
    output logic             msb,
    output logic             all_out
);
    localparam int FW = RES_W + 1;
    localparam int CW = $clog2(FW + 1);

    logic [FW-1:0] sreg;
    logic [CW-1:0] cnt;

    assign all_out = (cnt == CW'(FW));
    assign msb     = sreg[FW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            cnt  <= '0;
        end else if (load) begin
            sreg <= {1'b1, data};
            cnt  <= '0;
        end else if (shift && !all_out) begin
            sreg <= {sreg[FW-2:0], 1'b0};
            cnt  <= cnt + 1'b1;
        end
    end

    // R4: the bit counter never passes the frame length
    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(FW));

    // R4: every accepted falling edge advances exactly one bit
    a_r4_one_step: assert property (@(posedge clk) disable iff (rst)
        (shift && !all_out && !load) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/cvs_ctrl.sv
module cvs_ctrl
    import cvs_pkg::*;
#(
    parameter int ABORT_CYC = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_lvl,
    input  logic      sclk_lvl,
    input  logic      chan_sel,
    input  logic      conv_done,
    input  logic      all_out,
    output rd_state_e st,
    output logic      load,
    output logic      shift,
    output logic      conv_go,
    output logic      conv_ch
);
    localparam int AW = (ABORT_CYC > 1) ? $clog2(ABORT_CYC) : 1;

    rd_state_e st_nx;
    logic      cs_d, sclk_d;
    logic      cs_fall, sclk_fall, start_ok;
    logic [AW-1:0] ab_cnt;

    assign cs_fall   = cs_d & ~cs_lvl;
    assign sclk_fall = sclk_d & ~sclk_lvl;
    assign start_ok  = ((st == ST_RSTHI) || (st == ST_IDLE)) && cs_fall;
    assign load      = (st == ST_BUSY) && !cs_lvl && conv_done;
    assign shift     = (st == ST_XFER) && sclk_fall;

    always_comb begin
        st_nx = st;
        case (st)
            ST_RSTHI, ST_IDLE: if (cs_fall) st_nx = ST_BUSY;
            ST_BUSY: begin
                if (cs_lvl)         st_nx = ST_ABORT;
                else if (conv_done) st_nx = ST_XFER;
            end
            ST_XFER: begin
                if (cs_lvl)       st_nx = all_out ? ST_IDLE : ST_ABORT;
                else if (all_out) st_nx = ST_HOLD;
            end
            ST_HOLD:  if (cs_lvl) st_nx = ST_IDLE;
            ST_ABORT: if (ab_cnt == '0) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_RSTHI;
            cs_d    <= 1'b1;
            sclk_d  <= 1'b0;
            ab_cnt  <= '0;
            conv_go <= 1'b0;
            conv_ch <= 1'b0;
        end else begin
            st      <= st_nx;
            cs_d    <= cs_lvl;
            sclk_d  <= sclk_lvl;
            conv_go <= start_ok;
            if (start_ok) conv_ch <= chan_sel;
            if (st != ST_ABORT && st_nx == ST_ABORT) ab_cnt <= AW'(ABORT_CYC - 1);
            else if (st == ST_ABORT && ab_cnt != '0) ab_cnt <= ab_cnt - 1'b1;
        end
    end

    // R8: a new start inside the abandon window does not leave the window
    a_r8_refall_ignored: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ABORT && cs_fall && ab_cnt != '0) |=> (st == ST_ABORT && !conv_go));

    // R9: the busy state waits for the converter and ignores the serial clock
    a_r9_busy_waits: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BUSY && !conv_done && !cs_lvl) |=> (st == ST_BUSY));

    // R9: an idle block stays idle without a start edge
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !cs_fall) |=> (st == ST_IDLE && !conv_go));
endmodule

// File: rtl/cvs_readout.sv
module cvs_readout
    import cvs_pkg::*;
#(
    parameter int RES_W       = 15,
    parameter int SYNC_STAGES = 2,
    parameter int ABORT_CYC   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             chan_sel,
    input  logic [RES_W-1:0] conv_result,
    input  logic             conv_done,
    output logic             conv_go,
    output logic             conv_ch,
    output logic             sd_o,
    output logic             sd_oe
);
    rd_state_e st;
    logic      cs_lvl, sclk_lvl;
    logic      load, shift, msb, all_out;
    line_t     drv;

    cvs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst(rst), .async_in(cs_n), .sync_o(cs_lvl));

    cvs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
        .clk(clk), .rst(rst), .async_in(sclk), .sync_o(sclk_lvl));

    cvs_ctrl #(.ABORT_CYC(ABORT_CYC)) u_ctrl (
        .clk(clk), .rst(rst), .cs_lvl(cs_lvl), .sclk_lvl(sclk_lvl),
        .chan_sel(chan_sel), .conv_done(conv_done), .all_out(all_out),
        .st(st), .load(load), .shift(shift), .conv_go(conv_go), .conv_ch(conv_ch));

    cvs_shifter #(.RES_W(RES_W)) u_shift (
        .clk(clk), .rst(rst), .load(load), .data(conv_result),
        .shift(shift), .msb(msb), .all_out(all_out));

    assign drv   = line_drive(st, msb);
    assign sd_oe = drv.oe;
    assign sd_o  = drv.val;

    // R1: first cycle out of reset drives the line high
    a_r1_post_reset_high: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sd_oe && sd_o));

    // R2: the start request coincides with the busy indication
    a_r2_go_means_busy: assert property (@(posedge clk) disable iff (rst)
        conv_go |-> (sd_oe && !sd_o));

    // R3: a done strobe while busy turns the line into the ready level
    a_r3_ready_high: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BUSY && conv_done && !cs_lvl) |=> (sd_oe && sd_o));

    // R5: convert-start high after a full frame releases the line
    a_r5_release: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD && cs_lvl) |=> !sd_oe);

    // R7: the latched channel does not move during a conversion
    a_r7_chan_hold: assert property (@(posedge clk) disable iff (rst)
        (!conv_go && (st == ST_BUSY || st == ST_XFER || st == ST_HOLD)) |-> $stable(conv_ch));
endmodule

// File: tb/sim_cvs_readout.sv
module sim_cvs_readout;
    localparam int RES_W = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic chan_sel = 1'b0;
    logic [RES_W-1:0] conv_result = '0;
    logic conv_done = 1'b0;
    logic conv_go, conv_ch, sd_o, sd_oe;

    int n_cmp = 0;
    int n_bad = 0;
    int go_cnt = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cvs_readout #(.RES_W(RES_W), .SYNC_STAGES(2), .ABORT_CYC(8)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .chan_sel(chan_sel),
        .conv_result(conv_result), .conv_done(conv_done),
        .conv_go(conv_go), .conv_ch(conv_ch), .sd_o(sd_o), .sd_oe(sd_oe));

    always @(posedge clk) if (!rst && conv_go) go_cnt <= go_cnt + 1;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_line(input string req, input string what, input logic oe, input logic v);
        chk(sd_oe === oe && (oe == 1'b0 || sd_o === v), req, what,
            {30'd0, sd_oe, sd_o}, {30'd0, oe, v});
    endtask

    task automatic start_conv(input logic ch);
        chan_sel = ch;
        tick(1);
        cs_n = 1'b0;
        tick(5);
    endtask

    task automatic deliver(input logic [RES_W-1:0] res);
        conv_result = res;
        conv_done = 1'b1;
        tick(1);
        conv_done = 1'b0;
        tick(2);
    endtask

    task automatic sclk_pulse(output logic cap);
        sclk = 1'b1;
        tick(5);
        cap = sd_o;
        sclk = 1'b0;
        tick(5);
    endtask

    task automatic read_frame(output logic [RES_W:0] word);
        logic b;
        word = '0;
        for (int i = 0; i < RES_W + 1; i++) begin
            sclk_pulse(b);
            word = {word[RES_W-1:0], b};
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        tick(4);
        chk_line("R1", "line during reset", 1'b1, 1'b1);
        rst = 1'b0;
        tick(3);
        chk_line("R1", "line after reset", 1'b1, 1'b1);
        chk(go_cnt == 0, "R1", "no start request", go_cnt, 0);
        conv_done = 1'b1; tick(1); conv_done = 1'b0; tick(2);
        chk_line("R9", "done before any start", 1'b1, 1'b1);
    endtask

    task automatic t_frame(input logic ch, input logic [RES_W-1:0] res);
        int g0;
        logic b;
        logic [RES_W:0] word;
        g0 = go_cnt;
        start_conv(ch);
        chk_line("R2", "busy after start", 1'b1, 1'b0);
        chk(go_cnt == g0 + 1, "R2", "one start request", go_cnt, g0 + 1);
        chk(conv_ch === ch, "R2", "channel latched", conv_ch, ch);
        sclk_pulse(b);
        chk_line("R9", "sclk during busy", 1'b1, 1'b0);
        deliver(res);
        chk_line("R3", "ready after done", 1'b1, 1'b1);
        read_frame(word);
        chk(word === {1'b1, res}, "R4", "captured frame", word, {1'b1, res});
        chk_line("R5", "low after frame", 1'b1, 1'b0);
        cs_n = 1'b1;
        tick(6);
        chk_line("R5", "released after cs rise", 1'b0, 1'b0);
        conv_done = 1'b1; tick(1); conv_done = 1'b0; tick(2);
        chk_line("R9", "stray done while idle", 1'b0, 1'b0);
    endtask

    task automatic t_chan_hold;
        logic [RES_W:0] word;
        start_conv(1'b1);
        chan_sel = 1'b0;
        tick(3);
        chk(conv_ch === 1'b1, "R7", "channel held while busy", conv_ch, 1);
        deliver(15'h2D71);
        read_frame(word);
        chk(conv_ch === 1'b1, "R7", "channel held after frame", conv_ch, 1);
        chk(word === {1'b1, 15'h2D71}, "R4", "frame with channel change", word, {1'b1, 15'h2D71});
        cs_n = 1'b1;
        tick(6);
    endtask

    task automatic t_abort_mid;
        logic b;
        start_conv(1'b0);
        deliver(15'h1234);
        repeat (5) sclk_pulse(b);
        cs_n = 1'b1;
        tick(4);
        chk_line("R6", "driven low early in abort", 1'b1, 1'b0);
        tick(5);
        chk_line("R6", "still driven late in abort", 1'b1, 1'b0);
        tick(4);
        chk_line("R6", "released after abort", 1'b0, 1'b0);
    endtask

    task automatic t_abort_busy;
        int g0;
        start_conv(1'b1);
        g0 = go_cnt;
        cs_n = 1'b1;
        tick(13);
        chk_line("R6", "released after busy abort", 1'b0, 1'b0);
        deliver(15'h7FFF);
        chk_line("R9", "late done after abort", 1'b0, 1'b0);
        chk(go_cnt == g0, "R6", "no new request", go_cnt, g0);
    endtask

    task automatic t_refall;
        int g0;
        start_conv(1'b0);
        deliver(15'h0F0F);
        g0 = go_cnt;
        cs_n = 1'b1;
        tick(4);
        cs_n = 1'b0;
        tick(9);
        chk_line("R8", "released despite refall", 1'b0, 1'b0);
        chk(go_cnt == g0, "R8", "refall gave no request", go_cnt, g0);
        cs_n = 1'b1;
        tick(5);
        chk_line("R8", "still idle", 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_frame(1'b0, 15'h5A3C);
        t_frame(1'b1, 15'h0001);
        t_frame(1'b0, 15'h7FFF);
        t_chan_hold();
        t_abort_mid();
        t_abort_busy();
        t_refall();
        t_frame(1'b1, 15'h4000);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule